// File: doc/BRIEF.md
# Module Reset and Link Supervisor

This block sits inside a pluggable copper transceiver module. It turns a host-side reset pin and a supply-good indication into the module's internal reset. It decides when the base-X auto-negotiation engine is told to start, and it keeps watch over the received idle stream once the link is up. The pin is active high. The module pulls it up, so a host that leaves it undriven also keeps the module in reset. The pin is brought into the clock domain through a two-flop synchroniser.

All timing comes from one free-running clock. A prescaler divides the clock into ticks of `TICK_DIV` cycles. Every wait is then a parameter counted in ticks:

- power-up initialisation (`INIT_TICKS`)
- the gap from reset release to negotiation start (`RELEASE_TICKS`)
- the idle watchdog (`IDLE_TICKS`)
- the negotiation bypass (`BYPASS_TICKS`)

With the default values of one microsecond per tick at 125 MHz, these are 300 ms, 200 µs, 1 ms and 200 ms. The PCS, the negotiation engine and the analog supply monitor are outside the block. They appear only as the strobes `idle_seen`, `anx_done` and `supply_ok`.

The control is a five-state machine:

- **ST_POWERUP**: entered on block reset or loss of supply.
- **ST_HELD**: the pin holds the module in reset.
- **ST_RELEASE**: the internal reset is released and the block waits out the release gap.
- **ST_NEGOTIATE**: auto-negotiation is running.
- **ST_LINK**: the link is up.

The transitions are:

- **any→POWERUP**: supply lost.
- **any except POWERUP/HELD→HELD**: the synchronised pin is high.
- **POWERUP→HELD or →RELEASE**: the init timer has expired; the pin level picks which.
- **HELD→RELEASE**: the pin is low.
- **RELEASE→NEGOTIATE**: the release timer has expired.
- **NEGOTIATE→LINK (normal)**: `anx_done` is high.
- **NEGOTIATE→LINK (bypass)**: `bypass_en` is high and the bypass timer has expired.
- **LINK→NEGOTIATE**: the idle watchdog has expired.

Top module: `xcvr_reset_link_sup`

## Requirements
- R1: While `srst` is high, and on the first cycle after it, the outputs are `core_rst`=1 and `an_start`=`link_up`=`lock_lost`=`bypass_up`=0. A block reset also clears a set `lock_lost`.
- R2: While `supply_ok` is low, `core_rst` is 1 and `link_up` is 0. Loss of supply forces this from the next clock edge. After supply returns, `core_rst` falls INIT_TICKS×TICK_DIV cycles after the first edge that samples `supply_ok` high.
- R3: A high level on `rst_pin` forces `core_rst`=1 and `link_up`=0 at the third clock edge after it is first sampled. This includes an undriven pin, which the module pull-up makes high. These values hold for as long as the pin stays high, and no `an_start` occurs during that time.
- R4: When `rst_pin` goes low, `core_rst` falls at the third clock edge. `an_start` follows RELEASE_TICKS×TICK_DIV cycles later and is exactly one cycle wide.
- R5: In negotiation, `anx_done` sampled high at an edge raises `link_up` at that same edge, with `bypass_up`=0.
- R6: With `bypass_en` high, the link comes up BYPASS_TICKS×TICK_DIV cycles after `an_start` even without `anx_done`, and `bypass_up`=1. If `anx_done` arrives at that same edge it wins and `bypass_up`=0. With `bypass_en` low, the link never comes up without `anx_done`.
- R7: Each `idle_seen` sampled in the link state restarts the idle watchdog. After IDLE_TICKS×TICK_DIV cycles with none, `link_up` falls, `lock_lost` is set and `an_start` pulses, all at the same edge.
- R8: `lock_lost` stays set until the link comes up again, the pin resets the module, supply is lost, or `srst` is applied.
- R9: `bypass_up` is 0 whenever `link_up` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| srst | input | 1 | Synchronous active-high reset of this block |
| rst_pin | input | 1 | Asynchronous module reset pin, high = reset |
| supply_ok | input | 1 | Supply above its threshold |
| idle_seen | input | 1 | One-cycle strobe per received idle pattern |
| anx_done | input | 1 | Base-X auto-negotiation complete |
| bypass_en | input | 1 | Allow the link to come up after the bypass time |
| core_rst | output | 1 | Internal reset for the rest of the module |
| an_start | output | 1 | One-cycle pulse starting auto-negotiation |
| link_up | output | 1 | Link reported up |
| lock_lost | output | 1 | Link was dropped because idles stopped |
| bypass_up | output | 1 | Link came up through the bypass timer |

## Verification
The bench builds the block with TICK_DIV=2, INIT_TICKS=5, RELEASE_TICKS=3, IDLE_TICKS=4 and BYPASS_TICKS=6. Every wait therefore lasts 6 to 12 clock cycles instead of hundreds of milliseconds. At that scale, each timer's exact expiry edge can be checked cycle by cycle. So can the prescaler restart on every state change and the case where `anx_done` arrives on the very edge the bypass timer expires. Many full power-up, pin-reset and watchdog sequences also fit in one short run.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [2:0] {
        ST_POWERUP   = 3'd0,
        ST_HELD      = 3'd1,
        ST_RELEASE   = 3'd2,
        ST_NEGOTIATE = 3'd3,
        ST_LINK      = 3'd4
    } sup_state_t;

endpackage

// File: rtl/sup_pin_sync.sv
// Multi-stage synchroniser for an asynchronous level input.
module sup_pin_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic srst,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] stage_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (srst) stage_q[0] <= RESET_VAL;
                    else      stage_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (srst) stage_q[i] <= RESET_VAL;
                    else      stage_q[i] <= stage_q[i-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/sup_tick_gen.sv
// Divides the clock into ticks; restarts its phase on clr.
module sup_tick_gen #(
    parameter int DIV = 125
) (
    input  logic clk,
    input  logic srst,
    input  logic clr,
    output logic tick
);

    localparam int PRE_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PRE_W-1:0] LAST = PRE_W'(DIV - 1);

    logic [PRE_W-1:0] pre_q;

    assign tick = (pre_q == LAST);

    always_ff @(posedge clk) begin
        if (srst || clr)  pre_q <= '0;
        else if (tick)    pre_q <= '0;
        else              pre_q <= pre_q + 1'b1;
    end

endmodule

// File: rtl/sup_phase_timer.sv
// Counts ticks since clr; done on the tick that completes 'limit' ticks.
module sup_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         srst,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         done
);

    logic [W-1:0] cnt_q;
    logic [W-1:0] last;

    assign last = limit - 1'b1;
    assign done = tick && (cnt_q == last);

    always_ff @(posedge clk) begin
        if (srst || clr)                  cnt_q <= '0;
        else if (tick && cnt_q != last)   cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/xcvr_reset_link_sup.sv
module xcvr_reset_link_sup
    import sup_pkg::*;
#(
    parameter int TICK_DIV      = 125,
    parameter int INIT_TICKS    = 300000,
    parameter int RELEASE_TICKS = 200,
    parameter int IDLE_TICKS    = 1000,
    parameter int BYPASS_TICKS  = 200000,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic srst,
    input  logic rst_pin,
    input  logic supply_ok,
    input  logic idle_seen,
    input  logic anx_done,
    input  logic bypass_en,
    output logic core_rst,
    output logic an_start,
    output logic link_up,
    output logic lock_lost,
    output logic bypass_up
);

    localparam int MAX_A  = (INIT_TICKS > RELEASE_TICKS) ? INIT_TICKS : RELEASE_TICKS;
    localparam int MAX_B  = (IDLE_TICKS > BYPASS_TICKS) ? IDLE_TICKS : BYPASS_TICKS;
    localparam int MAX_T  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W  = $clog2(MAX_T + 1);

    sup_state_t       state_q, state_d;
    logic             pin_s;
    logic             tick;
    logic             t_clr;
    logic             t_done;
    logic [CNT_W-1:0] t_limit;

    sup_pin_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk  (clk),
        .srst (srst),
        .din  (rst_pin),
        .dout (pin_s)
    );

    sup_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .srst (srst),
        .clr  (t_clr),
        .tick (tick)
    );

    sup_phase_timer #(.W(CNT_W)) u_timer (
        .clk   (clk),
        .srst  (srst),
        .clr   (t_clr),
        .tick  (tick),
        .limit (t_limit),
        .done  (t_done)
    );

    // Timer length for the current phase.
    always_comb begin
        unique case (state_q)
            ST_POWERUP:   t_limit = CNT_W'(INIT_TICKS);
            ST_RELEASE:   t_limit = CNT_W'(RELEASE_TICKS);
            ST_NEGOTIATE: t_limit = CNT_W'(BYPASS_TICKS);
            ST_LINK:      t_limit = CNT_W'(IDLE_TICKS);
            default:      t_limit = CNT_W'(1);
        endcase
    end

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        if (!supply_ok) begin
            state_d = ST_POWERUP;
        end else if (pin_s && state_q != ST_POWERUP && state_q != ST_HELD) begin
            state_d = ST_HELD;
        end else begin
            unique case (state_q)
                ST_POWERUP: begin
                    if (t_done) state_d = pin_s ? ST_HELD : ST_RELEASE;
                end
                ST_HELD: begin
                    if (!pin_s) state_d = ST_RELEASE;
                end
                ST_RELEASE: begin
                    if (t_done) state_d = ST_NEGOTIATE;
                end
                ST_NEGOTIATE: begin
                    if (anx_done)                   state_d = ST_LINK;
                    else if (bypass_en && t_done)   state_d = ST_LINK;
                end
                ST_LINK: begin
                    if (t_done && !idle_seen) state_d = ST_NEGOTIATE;
                end
                default: state_d = ST_POWERUP;
            endcase
        end
    end

    // The timer and prescaler restart on every phase change, while supply is
    // absent during power-up, and on each idle seen with the link up.
    assign t_clr = (state_d != state_q)
                || (state_q == ST_POWERUP && !supply_ok)
                || (state_q == ST_LINK && idle_seen);

    // State register.
    always_ff @(posedge clk) begin
        if (srst) state_q <= ST_POWERUP;
        else      state_q <= state_d;
    end

    // Registered outputs, decoded from the state being entered.
    always_ff @(posedge clk) begin
        if (srst) begin
            core_rst  <= 1'b1;
            an_start  <= 1'b0;
            link_up   <= 1'b0;
            lock_lost <= 1'b0;
            bypass_up <= 1'b0;
        end else begin
            core_rst <= (state_d == ST_POWERUP) || (state_d == ST_HELD);
            link_up  <= (state_d == ST_LINK);
            an_start <= (state_d == ST_NEGOTIATE) && (state_q != ST_NEGOTIATE);

            if (state_d == ST_LINK && state_q != ST_LINK)
                bypass_up <= !anx_done;
            else if (state_d != ST_LINK)
                bypass_up <= 1'b0;

            if (state_q == ST_LINK && state_d == ST_NEGOTIATE)
                lock_lost <= 1'b1;
            else if (state_d == ST_LINK || state_d == ST_HELD || state_d == ST_POWERUP)
                lock_lost <= 1'b0;
        end
    end

endmodule

// File: rtl/sup_checker.sv
module sup_checker (
    input logic clk,
    input logic srst,
    input logic rst_pin,
    input logic supply_ok,
    input logic anx_done,
    input logic bypass_en,
    input logic core_rst,
    input logic an_start,
    input logic link_up,
    input logic lock_lost,
    input logic bypass_up
);

    // Edges seen so far with the pin continuously high, saturating at 3.
    logic [1:0] pin_run;
    always_ff @(posedge clk) begin
        if (srst || !rst_pin)  pin_run <= 2'd0;
        else if (pin_run != 2'd3) pin_run <= pin_run + 2'd1;
    end

    assert_r1_idle_after_reset_R1: assert property (@(posedge clk)
        $fell(srst) |-> core_rst && !link_up && !an_start && !lock_lost && !bypass_up);

    assert_supply_loss_R2: assert property (@(posedge clk) disable iff (srst)
        !supply_ok |=> core_rst && !link_up);

    assert_pin_drops_link_R3: assert property (@(posedge clk) disable iff (srst)
        (pin_run == 2'd3) |-> core_rst && !link_up && !an_start);

    assert_an_single_pulse_R4: assert property (@(posedge clk) disable iff (srst)
        an_start |=> !an_start);

    assert_an_out_of_reset_R4: assert property (@(posedge clk) disable iff (srst)
        an_start |-> !core_rst);

    assert_link_cause_R5: assert property (@(posedge clk) disable iff (srst)
        $rose(link_up) |-> $past(anx_done) || $past(bypass_en));

    assert_lock_loss_R7: assert property (@(posedge clk) disable iff (srst)
        $rose(lock_lost) |-> !link_up && an_start);

    assert_bypass_only_up_R9: assert property (@(posedge clk) disable iff (srst)
        bypass_up |-> link_up);

endmodule

bind xcvr_reset_link_sup sup_checker u_chk (
    .clk       (clk),
    .srst      (srst),
    .rst_pin   (rst_pin),
    .supply_ok (supply_ok),
    .anx_done  (anx_done),
    .bypass_en (bypass_en),
    .core_rst  (core_rst),
    .an_start  (an_start),
    .link_up   (link_up),
    .lock_lost (lock_lost),
    .bypass_up (bypass_up)
);

// File: tb/sim_xcvr_reset_link_sup.sv
module sim_xcvr_reset_link_sup;

    localparam int DIV = 2;
    localparam int INI = 5;
    localparam int REL = 3;
    localparam int IDL = 4;
    localparam int BYP = 6;

    logic clk = 1'b0;
    logic srst = 1'b1;
    logic rst_pin = 1'b0;
    logic supply_ok = 1'b1;
    logic idle_seen = 1'b0;
    logic anx_done = 1'b0;
    logic bypass_en = 1'b0;
    logic core_rst, an_start, link_up, lock_lost, bypass_up;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    xcvr_reset_link_sup #(
        .TICK_DIV(DIV), .INIT_TICKS(INI), .RELEASE_TICKS(REL),
        .IDLE_TICKS(IDL), .BYPASS_TICKS(BYP), .SYNC_STAGES(2)
    ) u0 (
        .clk(clk), .srst(srst), .rst_pin(rst_pin), .supply_ok(supply_ok),
        .idle_seen(idle_seen), .anx_done(anx_done), .bypass_en(bypass_en),
        .core_rst(core_rst), .an_start(an_start), .link_up(link_up),
        .lock_lost(lock_lost), .bypass_up(bypass_up)
    );

    // {bypass_en, cycle of anx_done drive after an_start (0 = never),
    //  expected cycle link_up is seen (0 = never), expected bypass_up}
    localparam int NV = 6;
    localparam int VEC [NV][4] = '{
        '{0, 3,  4,  0},
        '{1, 0,  12, 1},
        '{1, 5,  6,  0},
        '{0, 9,  10, 0},
        '{1, 11, 12, 0},
        '{0, 0,  0,  0}
    };

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic do_reset(input logic sup);
        srst = 1'b1; supply_ok = sup; rst_pin = 1'b0; idle_seen = 1'b0;
        anx_done = 1'b0; bypass_en = 1'b0;
        repeat (3) @(negedge clk);
        srst = 1'b0;
    endtask

    task automatic reach_neg();
        int t = 0;
        @(negedge clk);
        while (!an_start && t < 200) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic reach_link();
        reach_neg();
        anx_done = 1'b1;
        @(negedge clk);
        anx_done = 1'b0;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual %0d expected 0", cyc);
            finish_run();
        end
    end

    initial begin
        int k, got, rel_k, an_k, an_cnt, drops;

        // R1: reset state
        repeat (2) @(negedge clk);
        check("R1 reset outputs", {core_rst, an_start, link_up, lock_lost, bypass_up}, 5'b10000);

        // Vector table: negotiation outcomes (R5, R6)
        for (int v = 0; v < NV; v++) begin
            do_reset(1'b1);
            bypass_en = VEC[v][0][0];
            reach_neg();
            k = 0; got = 0;
            while (k < 40 && got == 0) begin
                anx_done = (VEC[v][1] != 0 && k == VEC[v][1]);
                @(negedge clk);
                k++;
                if (link_up) got = k;
            end
            anx_done = 1'b0;
            check(VEC[v][0] != 0 ? "R6 link cycle" : "R5 link cycle", got, VEC[v][2]);
            check(VEC[v][0] != 0 ? "R6 bypass flag" : "R5 bypass flag", int'(bypass_up), VEC[v][3]);
        end

        // R2: no supply holds reset
        do_reset(1'b0);
        repeat (30) @(negedge clk);
        check("R2 held without supply", {core_rst, link_up, an_start}, 3'b100);
        // R2 / R4: power-up and release timing
        supply_ok = 1'b1;
        rel_k = 0; an_k = 0; an_cnt = 0;
        for (int i = 1; i <= 20; i++) begin
            @(negedge clk);
            if (!core_rst && rel_k == 0) rel_k = i;
            if (an_start) begin
                an_cnt++;
                if (an_k == 0) an_k = i;
            end
        end
        check("R2 init length", rel_k, INI * DIV);
        check("R4 an_start after release", an_k - rel_k, REL * DIV);
        check("R4 an_start width", an_cnt, 1);

        // R7: idle strobes keep link up
        anx_done = 1'b1;
        @(negedge clk);
        anx_done = 1'b0;
        drops = 0;
        for (int i = 0; i < 40; i++) begin
            idle_seen = (i % 5 == 0);
            @(negedge clk);
            if (!link_up || lock_lost) drops++;
        end
        check("R7 link kept by idles", drops, 0);
        // R7: watchdog expiry
        idle_seen = 1'b1;
        got = 0; an_k = 0; k = 0;
        for (int i = 1; i <= 12; i++) begin
            @(negedge clk);
            idle_seen = 1'b0;
            if (!link_up && got == 0) begin
                got = i;
                k = {30'd0, lock_lost, an_start};
            end
        end
        check("R7 watchdog drop cycle", got, IDL * DIV + 1);
        check("R7 lock_lost and an_start", k, 3);
        // R8: lock_lost clears when link returns
        check("R8 lock_lost held in negotiation", int'(lock_lost), 1);
        anx_done = 1'b1;
        @(negedge clk);
        anx_done = 1'b0;
        check("R8 lock_lost cleared on link up", {link_up, lock_lost}, 2'b10);

        // R3: reset pin
        rst_pin = 1'b1;
        got = 0;
        for (int i = 1; i <= 5; i++) begin
            @(negedge clk);
            if (!link_up && core_rst && got == 0) got = i;
        end
        check("R3 link down delay", got, 3);
        an_cnt = 0; drops = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (an_start) an_cnt++;
            if (!core_rst) drops++;
        end
        check("R3 held while pin high", an_cnt + drops, 0);
        // R4: release from pin
        rst_pin = 1'b0;
        rel_k = 0; an_k = 0;
        for (int i = 1; i <= 14; i++) begin
            @(negedge clk);
            if (!core_rst && rel_k == 0) rel_k = i;
            if (an_start && an_k == 0) an_k = i;
        end
        check("R4 core_rst release", rel_k, 3);
        check("R4 an_start from pin", an_k, 3 + REL * DIV);

        // R2: supply loss during link
        anx_done = 1'b1;
        @(negedge clk);
        anx_done = 1'b0;
        supply_ok = 1'b0;
        @(negedge clk);
        check("R2 supply loss", {core_rst, link_up}, 2'b10);
        supply_ok = 1'b1;

        // R9: bypass flag drops with link
        do_reset(1'b1);
        bypass_en = 1'b1;
        reach_neg();
        k = 0;
        while (!link_up && k < 40) begin
            @(negedge clk);
            k++;
        end
        check("R9 bypass flag while up", int'(bypass_up), 1);
        repeat (IDL * DIV + 1) @(negedge clk);
        check("R9 bypass flag after drop", {link_up, bypass_up, lock_lost}, 3'b001);

        // R1: block reset clears lock_lost
        srst = 1'b1;
        @(negedge clk);
        srst = 1'b0;
        @(negedge clk);
        check("R1 srst clears flags", {core_rst, an_start, link_up, lock_lost, bypass_up}, 5'b10000);

        finish_run();
    end

endmodule